// File: doc/BRIEF.md
# I2C SCL Divider Encoder and Timing Generator

This block turns a requested clock divider ratio (system clock frequency over the wanted SCL frequency) into the compact timing setup used by an I2C master. It then runs a free-running SCL timing strobe from that setup. The ratio is halved until it fits in four bits, one halving per clock. Each halving adds one to a prescaler exponent. Any bit shifted out during the halving rounds the reduced ratio up by one. The reduced ratio is then split into a low-phase count and a high-phase count. The high phase gets the extra count when the split is uneven.

The fields are published separately and also packed into one 32-bit configuration word. A fast-mode request loads a bus timeout value of 3; otherwise the timeout is 0. The generator emits a single-cycle tick every 2^exponent clocks. It drives SCL low for low+1 ticks and then high for high+1 ticks. A new setup is taken on only when a full SCL period ends, so no period is ever cut short. Before the first setup is accepted, the generator is idle with SCL high.

Top module: `scl_timing_gen`

## Requirements
- R1: After an accepted load, the exponent equals the number of halvings needed to bring the ratio below 16 (for example, 100 gives 3 and 5000 gives 9).
- R2: If any bit shifted out during the halving is 1, the reduced ratio is incremented by one (for example, 31 reduces to 15 and rounds up to 16).
- R3: With reduced ratio r, the low count is (r>>1)-1 and the high count is r-low-2. The high count therefore always equals the low count or the low count plus one.
- R4: The configuration word holds the exponent in bits [3:0], the low count in [11:8], the high count in [15:12], the fast flag in bit 16 and the timeout in [23:20], with the constant 0xA5 in [31:24]. All other bits are zero. After reset the word is 0xA5000000.
- R5: When the fast input is high at load, the fast flag is 1 and the timeout field is 3. Otherwise both are 0.
- R6: cfg_valid falls one cycle after an accepted load. It rises k+1 cycles after the load edge, where k is the number of halvings. It is low after reset.
- R7: While running, scl_tick is high for one cycle every 2^exponent clocks.
- R8: Each SCL period starts with scl_phase low (0) for low+1 ticks, followed by scl_phase high (1) for high+1 ticks. scl_phase is 1 and scl_tick is 0 before the first setup is adopted.
- R9: A load with ratio 0 or 1 sets cfg_err and leaves every configuration output and cfg_valid unchanged. cfg_err is cleared by the next accepted load.
- R10: A newly reduced setup is adopted by the generator only at the end of a high phase. If the generator is idle, it adopts the setup two cycles after cfg_valid rises.
- R11: An accepted load during an ongoing reduction restarts the reduction with the new ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Strobe to accept ratio and fast_req |
| ratio | input | 16 | Requested divider ratio |
| fast_req | input | 1 | Selects fast mode with timeout for this load |
| cfg_word | output | 32 | Packed configuration word |
| cfg_exp | output | 4 | Prescaler exponent |
| cfg_high | output | 4 | High-phase count |
| cfg_low | output | 4 | Low-phase count |
| cfg_timeout | output | 4 | Timeout value (3 in fast mode, else 0) |
| cfg_fast | output | 1 | Fast mode selected |
| cfg_valid | output | 1 | Reduction finished, fields are current |
| cfg_err | output | 1 | Last rejected load had a ratio below 2 |
| scl_tick | output | 1 | One-cycle prescaler strobe |
| scl_phase | output | 1 | SCL level to drive (0 low, 1 high) |

## Verification
A wrong halving count or a lost sticky bit shows at the ports as soon as cfg_valid rises: the exponent or a phase count differs, and so does the packed word. A latency error shows as cfg_valid rising a cycle early or late. Faults in the prescaler or phase counters show within one SCL period as a tick or an scl_phase edge in the wrong cycle. A setup adopted mid-period shows as a shortened phase right after the load finishes. Comparing against a cycle-accurate reference on every clock catches each of these in the first cycle it occurs.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;
    localparam int RATIO_W   = 16;
    localparam int EXP_W     = $clog2(RATIO_W);
    localparam int PH_W      = 4;
    localparam int CFG_W     = 32;
    localparam int FIT_BITS  = 4;
    localparam logic [7:0] CFG_BASE     = 8'hA5;
    localparam logic [3:0] TIMEOUT_FAST = 4'd3;

    typedef struct packed {
        logic [EXP_W-1:0] exp;
        logic [PH_W-1:0]  high;
        logic [PH_W-1:0]  low;
        logic             fast;
    } scl_cfg_t;

    function automatic logic [3:0] timeout_of(scl_cfg_t c);
        return c.fast ? TIMEOUT_FAST : 4'd0;
    endfunction

    function automatic logic [CFG_W-1:0] pack_cfg(scl_cfg_t c);
        logic [CFG_W-1:0] w;
        w = '0;
        w[31:24]       = CFG_BASE;
        w[23:20]       = timeout_of(c);
        w[16]          = c.fast;
        w[15:12]       = c.high;
        w[11:8]        = c.low;
        w[EXP_W-1:0]   = c.exp;
        return w;
    endfunction
endpackage

// File: rtl/scl_ratio_reducer.sv
module scl_ratio_reducer
    import scl_div_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [RATIO_W-1:0] ratio,
    input  logic               fast_req,
    output scl_cfg_t           res,
    output logic               valid,
    output logic               err,
    output logic               done
);
    logic [RATIO_W-1:0] work;
    logic [EXP_W-1:0]   exp_q;
    logic               sticky;
    logic               busy;
    logic               fast_q;
    logic               accept;
    logic               fits;
    logic [FIT_BITS:0]  red;
    logic [PH_W-1:0]    lo;
    logic [FIT_BITS:0]  hi5;

    assign accept = load && (ratio > RATIO_W'(1));
    assign fits   = (work < RATIO_W'(16));

    always_comb begin
        red = {1'b0, work[FIT_BITS-1:0]} + {{FIT_BITS{1'b0}}, sticky};
        lo  = PH_W'(red[FIT_BITS:1]) - PH_W'(1);
        hi5 = red - {1'b0, lo} - 5'd2;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            work   <= '0;
            exp_q  <= '0;
            sticky <= 1'b0;
            busy   <= 1'b0;
            fast_q <= 1'b0;
            res    <= '0;
            valid  <= 1'b0;
            err    <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                work   <= ratio;
                exp_q  <= '0;
                sticky <= 1'b0;
                busy   <= 1'b1;
                fast_q <= fast_req;
                valid  <= 1'b0;
                err    <= 1'b0;
            end else begin
                if (load) err <= 1'b1;
                if (busy) begin
                    if (!fits) begin
                        work   <= work >> 1;
                        sticky <= sticky | work[0];
                        exp_q  <= exp_q + EXP_W'(1);
                    end else begin
                        res.exp  <= exp_q;
                        res.low  <= lo;
                        res.high <= hi5[PH_W-1:0];
                        res.fast <= fast_q;
                        busy     <= 1'b0;
                        valid    <= 1'b1;
                        done     <= 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen
    import scl_div_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             new_cfg,
    input  logic [EXP_W-1:0] nx_exp,
    input  logic [PH_W-1:0]  nx_low,
    input  logic [PH_W-1:0]  nx_high,
    output logic             tick,
    output logic             phase
);
    localparam logic [RATIO_W-1:0] ONE = RATIO_W'(1);

    logic               run;
    logic               pend;
    logic [EXP_W-1:0]   a_exp;
    logic [PH_W-1:0]    a_low;
    logic [PH_W-1:0]    a_high;
    logic [RATIO_W-1:0] pcnt;
    logic [PH_W-1:0]    tcnt;
    logic [RATIO_W-1:0] mask;
    logic [PH_W-1:0]    lim;
    logic               adopt;

    assign mask = (ONE << a_exp) - ONE;
    assign tick = run && (pcnt == mask);
    assign lim  = phase ? a_high : a_low;

    always_comb begin
        adopt = 1'b0;
        if (!run) adopt = pend;
        else if (tick && (tcnt == lim) && phase) adopt = pend;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run    <= 1'b0;
            pend   <= 1'b0;
            a_exp  <= '0;
            a_low  <= '0;
            a_high <= '0;
            pcnt   <= '0;
            tcnt   <= '0;
            phase  <= 1'b1;
        end else begin
            pend <= new_cfg ? 1'b1 : (adopt ? 1'b0 : pend);
            if (adopt) begin
                a_exp  <= nx_exp;
                a_low  <= nx_low;
                a_high <= nx_high;
            end
            if (!run) begin
                if (pend) begin
                    run   <= 1'b1;
                    pcnt  <= '0;
                    tcnt  <= '0;
                    phase <= 1'b0;
                end
            end else if (tick) begin
                pcnt <= '0;
                if (tcnt == lim) begin
                    tcnt  <= '0;
                    phase <= ~phase;
                end else begin
                    tcnt <= tcnt + PH_W'(1);
                end
            end else begin
                pcnt <= pcnt + ONE;
            end
        end
    end
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
    import scl_div_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [RATIO_W-1:0] ratio,
    input  logic               fast_req,
    output logic [CFG_W-1:0]   cfg_word,
    output logic [EXP_W-1:0]   cfg_exp,
    output logic [PH_W-1:0]    cfg_high,
    output logic [PH_W-1:0]    cfg_low,
    output logic [3:0]         cfg_timeout,
    output logic               cfg_fast,
    output logic               cfg_valid,
    output logic               cfg_err,
    output logic               scl_tick,
    output logic               scl_phase
);
    scl_cfg_t res;
    logic     done;

    scl_ratio_reducer u_red (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .ratio    (ratio),
        .fast_req (fast_req),
        .res      (res),
        .valid    (cfg_valid),
        .err      (cfg_err),
        .done     (done)
    );

    scl_phase_gen u_gen (
        .clk     (clk),
        .rst     (rst),
        .new_cfg (done),
        .nx_exp  (res.exp),
        .nx_low  (res.low),
        .nx_high (res.high),
        .tick    (scl_tick),
        .phase   (scl_phase)
    );

    assign cfg_word    = pack_cfg(res);
    assign cfg_exp     = res.exp;
    assign cfg_high    = res.high;
    assign cfg_low     = res.low;
    assign cfg_fast    = res.fast;
    assign cfg_timeout = timeout_of(res);
endmodule

// File: rtl/scl_timing_gen_chk.sv
module scl_timing_gen_chk (
    input logic        clk,
    input logic        rst,
    input logic        load,
    input logic [15:0] ratio,
    input logic [31:0] cfg_word,
    input logic [3:0]  cfg_high,
    input logic [3:0]  cfg_low,
    input logic        cfg_valid,
    input logic        cfg_err,
    input logic        scl_tick,
    input logic        scl_phase
);
    assert_reject_flag_R9: assert property (@(posedge clk) disable iff (rst)
        (load && ratio < 16'd2) |=> cfg_err);

    assert_reject_keeps_cfg_R9: assert property (@(posedge clk) disable iff (rst)
        (load && ratio < 16'd2 && cfg_valid) |=> ($stable(cfg_word) && cfg_valid));

    assert_accept_clears_R6: assert property (@(posedge clk) disable iff (rst)
        (load && ratio >= 16'd2) |=> (!cfg_valid && !cfg_err));

    assert_split_balance_R3: assert property (@(posedge clk) disable iff (rst)
        cfg_valid |-> ((cfg_high == cfg_low) || (cfg_high == cfg_low + 4'd1)));

    assert_high_needs_tick_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(scl_phase) |-> $past(scl_tick));
endmodule

bind scl_timing_gen scl_timing_gen_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .ratio     (ratio),
    .cfg_word  (cfg_word),
    .cfg_high  (cfg_high),
    .cfg_low   (cfg_low),
    .cfg_valid (cfg_valid),
    .cfg_err   (cfg_err),
    .scl_tick  (scl_tick),
    .scl_phase (scl_phase)
);

// File: tb/scl_timing_gen_test.sv
`timescale 1ns/1ps
module scl_timing_gen_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load = 1'b0;
    logic [15:0] ratio = '0;
    logic        fast_req = 1'b0;
    logic [31:0] cfg_word;
    logic [3:0]  cfg_exp, cfg_high, cfg_low, cfg_timeout;
    logic        cfg_fast, cfg_valid, cfg_err, scl_tick, scl_phase;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done_flag = 0;

    always #2.5 clk = ~clk;

    scl_timing_gen uut (
        .clk(clk), .rst(rst), .load(load), .ratio(ratio), .fast_req(fast_req),
        .cfg_word(cfg_word), .cfg_exp(cfg_exp), .cfg_high(cfg_high),
        .cfg_low(cfg_low), .cfg_timeout(cfg_timeout), .cfg_fast(cfg_fast),
        .cfg_valid(cfg_valid), .cfg_err(cfg_err), .scl_tick(scl_tick),
        .scl_phase(scl_phase)
    );

    task automatic check(input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d",
                     req, what, act, exp, cycles);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // reference model state
    int m_run, m_flag, m_done, m_busy, m_left, m_valid, m_err;
    int m_pc, m_cnt, m_phase;
    int a_exp, a_low, a_high;
    int r_exp, r_low, r_high, r_fast;
    int p_exp, p_low, p_high, p_fast;
    bit model_on = 0;

    task automatic reduce(input int rv, output int e, output int lo, output int hi);
        int s;
        s = 0; e = 0;
        while (rv >= 16) begin
            s = s | (rv & 1);
            rv = rv >> 1;
            e++;
        end
        rv = rv + s;
        lo = rv / 2 - 1;
        hi = rv - lo - 2;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_run = 0; m_flag = 0; m_done = 0; m_busy = 0; m_left = 0;
            m_valid = 0; m_err = 0; m_pc = 0; m_cnt = 0; m_phase = 1;
            a_exp = 0; a_low = 0; a_high = 0;
            r_exp = 0; r_low = 0; r_high = 0; r_fast = 0;
        end else begin
            int adopt, lim, tk;
            adopt = 0;
            tk = m_run && (m_pc == (1 << a_exp) - 1);
            if (!m_run) begin
                if (m_flag) begin
                    m_run = 1; m_pc = 0; m_cnt = 0; m_phase = 0;
                    a_exp = r_exp; a_low = r_low; a_high = r_high; adopt = 1;
                end
            end else if (tk) begin
                m_pc = 0;
                lim = m_phase ? a_high : a_low;
                if (m_cnt == lim) begin
                    m_cnt = 0;
                    if (m_phase == 1 && m_flag) begin
                        a_exp = r_exp; a_low = r_low; a_high = r_high; adopt = 1;
                    end
                    m_phase = 1 - m_phase;
                end else m_cnt++;
            end else m_pc++;
            m_flag = m_done ? 1 : (adopt ? 0 : m_flag);
            m_done = 0;
            if (load && ratio >= 2) begin
                int e, lo, hi;
                reduce(int'(ratio), e, lo, hi);
                p_exp = e; p_low = lo; p_high = hi; p_fast = fast_req;
                m_left = e + 1; m_busy = 1; m_valid = 0; m_err = 0;
            end else begin
                if (load) m_err = 1;
                if (m_busy) begin
                    m_left--;
                    if (m_left == 0) begin
                        m_busy = 0; m_valid = 1; m_done = 1;
                        r_exp = p_exp; r_low = p_low; r_high = p_high; r_fast = p_fast;
                    end
                end
            end
        end
        if (cycles > 190000) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 190000);
            finish_run();
        end
    end

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (model_on && !rst) begin
            longint w;
            w = (64'hA5 << 24) | (longint'(r_fast ? 3 : 0) << 20) | (longint'(r_fast) << 16)
              | (longint'(r_high) << 12) | (longint'(r_low) << 8) | longint'(r_exp);
            check("R6", "cfg_valid", cfg_valid, m_valid);
            check("R9", "cfg_err", cfg_err, m_err);
            check("R1 R2 R3", "exp/low/high",
                  {cfg_exp, cfg_low, cfg_high}, {4'(r_exp), 4'(r_low), 4'(r_high)});
            check("R4 R5", "cfg_word", cfg_word, w);
            check("R7", "scl_tick", scl_tick, (m_run && (m_pc == (1 << a_exp) - 1)));
            check("R8 R10", "scl_phase", scl_phase, m_phase);
        end
    end

    task automatic do_load(input int rv, input bit f);
        @(negedge clk);
        load = 1'b1; ratio = 16'(rv); fast_req = f;
        @(negedge clk);
        load = 1'b0; fast_req = 1'b0;
    endtask

    task automatic wait_valid();
        int n;
        n = 0;
        while (!cfg_valid && n < 40) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state
        check("R4", "reset word", cfg_word, 32'hA500_0000);
        check("R6", "reset valid", cfg_valid, 0);
        check("R8", "idle phase high", scl_phase, 1);
        check("R8", "idle no tick", scl_tick, 0);
        model_on = 1;

        do_load(0, 0);
        check("R9", "zero ratio err", cfg_err, 1);
        check("R9", "zero ratio no valid", cfg_valid, 0);
        idle(5);
        check("R9", "zero ratio idle phase", scl_phase, 1);

        do_load(100, 0);
        check("R6", "valid low during reduction", cfg_valid, 0);
        check("R9", "err cleared by accept", cfg_err, 0);
        wait_valid();
        check("R1", "exp of 100", cfg_exp, 3);
        check("R3", "low/high of 100", {cfg_low, cfg_high}, {4'd5, 4'd6});
        check("R4", "word of 100", cfg_word, 32'hA500_6503);
        check("R5", "normal timeout", cfg_timeout, 0);
        idle(700);

        do_load(31, 1);
        wait_valid();
        check("R2", "31 rounds to 16", {cfg_exp, cfg_low, cfg_high}, {4'd1, 4'd7, 4'd7});
        check("R5", "fast timeout", {cfg_fast, cfg_timeout}, {1'b1, 4'd3});
        check("R4", "word of 31 fast", cfg_word, 32'hA531_7701);
        idle(300);

        do_load(1, 0);
        check("R9", "ratio 1 err", cfg_err, 1);
        check("R9", "ratio 1 keeps word", cfg_word, 32'hA531_7701);
        check("R9", "ratio 1 keeps valid", cfg_valid, 1);
        idle(50);

        do_load(2, 0);
        wait_valid();
        check("R3", "ratio 2 split", {cfg_exp, cfg_low, cfg_high}, 12'h000);
        idle(100);

        do_load(5000, 0);
        do_load(40, 0);
        wait_valid();
        check("R11", "restart with 40", cfg_word, 32'hA500_4402);
        idle(1000);

        do_load(5000, 0);
        wait_valid();
        check("R1", "exp of 5000", cfg_exp, 9);
        check("R2", "5000 split", {cfg_low, cfg_high}, {4'd4, 4'd4});
        idle(12000);

        finish_run();
    end
endmodule